// File: doc/BRIEF.md
# NAND Flash Pin Sequencer

This block sits between a simple byte-wide host bus and the pins of one NAND flash device. Each host access is turned into one pin cycle. Host address bits pick the kind of cycle: a command latch, an address latch, or a plain data transfer. Chip enable is low for the whole cycle. Every cycle runs through four timed phases: setup, strobe, hold and an optional bus-turnaround gap. The length of each phase comes from one of two timing words.

A high address bit steers an access to the attribute timing word instead of the common one. Software uses this for the final address byte on devices that need chip enable to stay low through the busy pulse that follows. A hold of eight or more cycles covers the device's write-to-busy delay, so the block is still active when ready/busy goes low. The block then keeps chip enable low until the device is ready again.

Ready/busy is synchronized internally. No access reaches its setup phase while the synchronized level is low, and chip enable stays low during that wait. The host sees `host_busy` high until the pin cycle and any ready wait have finished. Requests are only taken while `host_busy` is low.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, chip enable, both strobes and `host_busy` are inactive (`nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_dq_oe`=0, `host_busy`=0).
- R2: A host write with address bit 16 set produces a command cycle. `nand_cle` is high for the setup, strobe and hold phases, and `nand_ale` stays low.
- R3: A host write with bit 16 clear and bit 17 set produces an address cycle with `nand_ale` high for the setup, strobe and hold phases. Successive address writes each produce their own cycle, with the bytes on `nand_dq_out` in issue order.
- R4: A host write with bits 16 and 17 clear produces a data write cycle with both latches low.
- R5: A host read produces a read cycle with `nand_re_n` low and both latches low, whatever bits 16 and 17 hold. The byte on `nand_dq_in` during the last strobe cycle is returned on `host_rdata`, with `host_rvalid` high for one cycle.
- R6: Timing words pack four 8-bit fields: setup [7:0], strobe [15:8], hold [23:16], gap [31:24]. Address bit 27 set selects `att_timing`, clear selects `com_timing`.
- R7: The phases last setup+1, strobe+1, hold+1 and gap cycles in that order. Chip enable stays low throughout. `nand_dq_oe` is high, with the write byte on `nand_dq_out`, only in write strobe cycles.
- R8: While synchronized ready/busy is low, no setup phase begins. Chip enable is held low and the write and read strobes stay high.
- R9: If ready/busy is low at the end of an access, chip enable stays low and `host_busy` stays high until it is high again. Chip enable releases at most four cycles after the pin rises.
- R10: `host_busy` goes high the cycle after a request is taken and stays high until the block is idle. A request made while `host_busy` is high starts no access.
- R11: The write and read strobes are never low together, `nand_cle` and `nand_ale` are never high together, and no strobe or data drive occurs while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken while host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 28 | Byte address; bits 16, 17 and 27 are decoded |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | One-cycle pulse marking host_rdata valid |
| host_busy | output | 1 | Stall: access or ready wait in progress |
| com_timing | input | 32 | Common timing word |
| att_timing | input | 32 | Attribute timing word |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |

## Verification
A phase counter that slips shows up within the same access as a strobe or chip-enable window whose length differs from the field value plus one. A decoding slip flips `nand_cle` or `nand_ale`, or picks the wrong timing word, on the very access that carries the bad address. A ready/busy fault shows up later, at the following access boundary: either a strobe appears while the pin is low, or chip enable releases during the busy pulse after an extended-hold write. A lost or extra request shows up as a missing or extra strobe once `host_busy` has fallen.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int FW = 8;

  typedef struct packed {
    logic [FW-1:0] gap;
    logic [FW-1:0] hold;
    logic [FW-1:0] strobe;
    logic [FW-1:0] setup;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_GAP    = 3'd5,
    PH_POST   = 3'd6
  } phase_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_pin,
  output logic rb_ok
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= rb_pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], rb_pin};
      end
    end
  endgenerate

  assign rb_ok = chain[STAGES-1];
endmodule

// File: rtl/nand_req_decode.sv
module nand_req_decode
  import nand_seq_pkg::*;
#(
  parameter int AW      = 28,
  parameter int DW      = 8,
  parameter int CMD_BIT = 16,
  parameter int ADR_BIT = 17,
  parameter int ATT_BIT = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  timing_t       com_timing,
  input  timing_t       att_timing,
  output logic          cur_we,
  output logic          cur_cle,
  output logic          cur_ale,
  output logic [DW-1:0] cur_wdata,
  output timing_t       cur_tim
);
  logic    dec_cle, dec_ale;
  timing_t dec_tim;

  always_comb begin
    dec_cle = host_we & host_addr[CMD_BIT];
    dec_ale = host_we & ~host_addr[CMD_BIT] & host_addr[ADR_BIT];
    dec_tim = host_addr[ATT_BIT] ? att_timing : com_timing;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_we    <= 1'b0;
      cur_cle   <= 1'b0;
      cur_ale   <= 1'b0;
      cur_wdata <= '0;
      cur_tim   <= '0;
    end else if (accept) begin
      cur_we    <= host_we;
      cur_cle   <= dec_cle;
      cur_ale   <= dec_ale;
      cur_wdata <= host_wdata;
      cur_tim   <= dec_tim;
    end
  end

  // R11
  latch_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !(cur_cle && cur_ale));

  // R5
  read_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !cur_we |-> (!cur_cle && !cur_ale));
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          rb_ok,
  input  logic          cur_we,
  input  timing_t       cur_tim,
  input  logic [DW-1:0] dq_in,
  output phase_e        phase,
  output logic          accept,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  phase_e        nxt;
  logic [FW-1:0] cnt;
  logic          last;

  always_comb begin
    unique case (phase)
      PH_SETUP:  last = (cnt == cur_tim.setup);
      PH_STROBE: last = (cnt == cur_tim.strobe);
      PH_HOLD:   last = (cnt == cur_tim.hold);
      PH_GAP:    last = (cnt == cur_tim.gap - 1'b1);
      default:   last = 1'b0;
    endcase
  end

  always_comb begin
    nxt    = phase;
    accept = 1'b0;
    unique case (phase)
      PH_IDLE: if (host_req) begin
        accept = 1'b1;
        nxt    = rb_ok ? PH_SETUP : PH_PRE;
      end
      PH_PRE:    if (rb_ok) nxt = PH_SETUP;
      PH_SETUP:  if (last) nxt = PH_STROBE;
      PH_STROBE: if (last) nxt = PH_HOLD;
      PH_HOLD: if (last) begin
        if (cur_tim.gap != '0) nxt = PH_GAP;
        else                   nxt = rb_ok ? PH_IDLE : PH_POST;
      end
      PH_GAP:  if (last) nxt = rb_ok ? PH_IDLE : PH_POST;
      PH_POST: if (rb_ok) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      phase  <= nxt;
      cnt    <= (nxt != phase) ? '0 : cnt + 1'b1;
      rvalid <= 1'b0;
      if (phase == PH_STROBE && last && !cur_we) begin
        rdata  <= dq_in;
        rvalid <= 1'b1;
      end
    end
  end

  // R8
  setup_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> $past(rb_ok));

  // R7
  phase_count_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == $past(phase) && (phase == PH_SETUP || phase == PH_STROBE ||
     phase == PH_HOLD || phase == PH_GAP)) |-> (cnt == $past(cnt) + 1'b1));

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int AW        = 28,
  parameter int DW        = 8,
  parameter int CMD_BIT   = 16,
  parameter int ADR_BIT   = 17,
  parameter int ATT_BIT   = 27,
  parameter int RB_STAGES = 2,
  localparam int TIMW     = 4 * FW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rvalid,
  output logic            host_busy,
  input  logic [TIMW-1:0] com_timing,
  input  logic [TIMW-1:0] att_timing,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DW-1:0]   nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DW-1:0]   nand_dq_in,
  input  logic            nand_rb
);
  logic          rb_ok, accept;
  logic          cur_we, cur_cle, cur_ale;
  logic [DW-1:0] cur_wdata;
  timing_t       cur_tim;
  phase_e        phase;
  logic          latch_win, strobe_ph;

  nand_rb_sync #(.STAGES(RB_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rb_pin(nand_rb), .rb_ok(rb_ok)
  );

  nand_req_decode #(
    .AW(AW), .DW(DW), .CMD_BIT(CMD_BIT), .ADR_BIT(ADR_BIT), .ATT_BIT(ATT_BIT)
  ) u_dec (
    .clk(clk), .rst(rst), .accept(accept), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .com_timing(timing_t'(com_timing)), .att_timing(timing_t'(att_timing)),
    .cur_we(cur_we), .cur_cle(cur_cle), .cur_ale(cur_ale),
    .cur_wdata(cur_wdata), .cur_tim(cur_tim)
  );

  nand_phase_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .host_req(host_req), .rb_ok(rb_ok),
    .cur_we(cur_we), .cur_tim(cur_tim), .dq_in(nand_dq_in),
    .phase(phase), .accept(accept), .rdata(host_rdata), .rvalid(host_rvalid)
  );

  always_comb begin
    latch_win   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strobe_ph   = (phase == PH_STROBE);
    host_busy   = (phase != PH_IDLE);
    nand_ce_n   = (phase == PH_IDLE);
    nand_cle    = latch_win & cur_cle;
    nand_ale    = latch_win & cur_ale;
    nand_we_n   = ~(strobe_ph & cur_we);
    nand_re_n   = ~(strobe_ph & ~cur_we);
    nand_dq_oe  = strobe_ph & cur_we;
    nand_dq_out = cur_wdata;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  // R11
  ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
    nand_ce_n |-> (nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_busy) |=> host_busy);

  // R9
  ce_release_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_ce_n) |-> $past(rb_ok));
endmodule

// File: tb/nand_seq_top_test.sv
module nand_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] COM_T = 32'h00010201; // setup1 strobe2 hold1 gap0
  localparam logic [31:0] ATT_T = 32'h02070100; // setup0 strobe1 hold7 gap2
  localparam int NVEC = 9;
  // {we, addr[27:0], wdata, device read byte}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 28'h0010000, 8'h00, 8'h00},
    {1'b1, 28'h0020000, 8'h11, 8'h00},
    {1'b1, 28'h0020000, 8'h22, 8'h00},
    {1'b1, 28'h8020000, 8'h03, 8'h00},
    {1'b0, 28'h0000000, 8'h00, 8'hA5},
    {1'b0, 28'h0000000, 8'h00, 8'h5A},
    {1'b1, 28'h0000000, 8'h3C, 8'h00},
    {1'b0, 28'h8030000, 8'h00, 8'hC3},
    {1'b1, 28'h8010000, 8'h30, 8'h00}
  };

  logic clk = 0, rst = 1;
  logic host_req = 0, host_we = 0;
  logic [27:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata, nand_dq_out, nand_dq_in = '0;
  logic host_rvalid, host_busy, nand_ce_n, nand_cle, nand_ale;
  logic nand_we_n, nand_re_n, nand_dq_oe, nand_rb;
  logic hold_low = 0, dev_arm = 0, prev_we = 1;
  int   dev_t = 0;
  int   checks = 0, failures = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // device ready/busy model: busy pulse starts 3 cycles after a write strobe ends
  always @(posedge clk) begin
    prev_we <= nand_we_n;
    if (dev_t != 0) dev_t <= (dev_t >= 28) ? 0 : dev_t + 1;
    else if (dev_arm && !prev_we && nand_we_n) dev_t <= 1;
  end
  assign nand_rb = !(hold_low || (dev_t >= 3 && dev_t < 28));

  nand_seq_top uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_busy(host_busy),
    .com_timing(COM_T), .att_timing(ATT_T),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts gathered over one access
  int n_ce, n_cle, n_ale, n_we, n_re, n_oe, n_bad_dq, n_rv, n_strobe_while_rb;
  logic [7:0] got_rd;

  task automatic run_access(input bit we, input logic [27:0] addr, input logic [7:0] wd);
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = addr; host_wdata = wd;
    n_ce = 0; n_cle = 0; n_ale = 0; n_we = 0; n_re = 0; n_oe = 0;
    n_bad_dq = 0; n_rv = 0; n_strobe_while_rb = 0; got_rd = '0;
    @(negedge clk);
    host_req = 0;
    while (host_busy) begin
      if (!nand_ce_n) n_ce++;
      if (nand_cle) n_cle++;
      if (nand_ale) n_ale++;
      if (!nand_we_n) begin
        n_we++;
        if (nand_dq_out != wd) n_bad_dq++;
      end
      if (!nand_re_n) n_re++;
      if (nand_dq_oe) n_oe++;
      if (host_rvalid) begin n_rv++; got_rd = host_rdata; end
      @(negedge clk);
    end
    if (host_rvalid) begin n_rv++; got_rd = host_rdata; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
        !nand_dq_oe && !host_busy, "R1 idle pins", {nand_ce_n, host_busy}, 2);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && !host_busy, "R1 after release", nand_ce_n, 1);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic we; logic [27:0] a; logic [7:0] wd, rd;
      logic [31:0] t; int s, w, h, g; bit cle_e, ale_e;
      {we, a, wd, rd} = VEC[i];
      nand_dq_in = rd;
      t = a[27] ? ATT_T : COM_T;
      s = t[7:0]; w = t[15:8]; h = t[23:16]; g = t[31:24];
      cle_e = we & a[16];
      ale_e = we & !a[16] & a[17];
      run_access(we, a, wd);
      chk(n_ce == s + w + h + 3 + g, "R7 ce window", n_ce, s + w + h + 3 + g);
      chk(n_cle == (cle_e ? s + w + h + 3 : 0), "R2 cle window", n_cle,
          cle_e ? s + w + h + 3 : 0);
      chk(n_ale == (ale_e ? s + w + h + 3 : 0), "R3 ale window", n_ale,
          ale_e ? s + w + h + 3 : 0);
      chk(n_we == (we ? w + 1 : 0), "R6 write strobe width", n_we, we ? w + 1 : 0);
      chk(n_re == (we ? 0 : w + 1), "R5 read strobe width", n_re, we ? 0 : w + 1);
      chk(n_oe == n_we && n_bad_dq == 0, "R4 data drive", n_oe + n_bad_dq, n_we);
      if (!we) begin
        chk(n_rv == 1, "R5 rvalid count", n_rv, 1);
        chk(got_rd == rd, "R5 read byte", got_rd, rd);
      end
    end

    // R8: ready low before request stalls the access
    hold_low = 1;
    repeat (3) @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 28'h0; host_wdata = 8'h77;
    @(negedge clk);
    host_req = 0;
    begin
      int bad = 0;
      for (int k = 0; k < 10; k++) begin
        if (nand_ce_n || !nand_we_n || !host_busy) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 stall with ce low", bad, 0);
    end
    hold_low = 0;
    begin
      int wl = 0, cyc = 0;
      while (host_busy && cyc < 50) begin
        if (!nand_we_n) wl++;
        cyc++;
        @(negedge clk);
      end
      chk(wl == 3, "R8 strobe after ready", wl, 3);
    end

    // R9: extended hold covers busy pulse
    dev_arm = 1;
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 28'h8020000; host_wdata = 8'h01;
    @(negedge clk);
    host_req = 0;
    begin
      int viol = 0, seen_low = 0, after_rise = 0;
      bit rose = 0;
      while (host_busy && after_rise < 20) begin
        if (!nand_rb) begin
          seen_low++;
          if (nand_ce_n) viol++;
        end else if (seen_low > 0) begin
          rose = 1;
        end
        if (rose) after_rise++;
        @(negedge clk);
      end
      chk(seen_low > 0, "R9 busy pulse observed", seen_low, 25);
      chk(viol == 0, "R9 ce low during busy", viol, 0);
      chk(rose && after_rise <= 4, "R9 ce release latency", after_rise, 4);
      chk(nand_ce_n, "R9 ce released", nand_ce_n, 1);
    end
    dev_arm = 0;
    repeat (3) @(negedge clk);

    // R10: request during busy is ignored
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 28'h0; host_wdata = 8'h44;
    @(negedge clk);
    chk(host_busy, "R10 busy after accept", host_busy, 1);
    host_wdata = 8'h55;
    @(negedge clk);
    host_req = 0;
    begin
      int strobes = 0, cyc = 0;
      while (host_busy && cyc < 50) begin
        if (!nand_we_n) strobes++;
        cyc++;
        @(negedge clk);
      end
      for (int k = 0; k < 8; k++) begin
        if (!nand_we_n || !nand_ce_n) strobes++;
        @(negedge clk);
      end
      chk(strobes == 3, "R10 single access", strobes, 3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule